// File: doc/BRIEF.md
# Interlaced TV Encoder Output Sequencer

This block produces the line and field timing for a synchronous 8-bit video link into a TV encoder. It also streams the pixel components for each line out of a ready/valid source. A line lasts `cfgActive + cfgBlank` pixel clocks. The line starts with a one-clock low pulse on the horizontal strobe, and the active slots follow straight after that pulse. A field lasts `cfgLines` lines. Fields alternate odd and even.

Field parity is carried only by where the vertical strobe falls. When an odd field starts, which also starts a new frame, the vertical strobe falls on the same clock as the horizontal strobe. When an even field starts, it falls a programmable number of clocks later within that same first line. Each component sits in the upper byte lane of an 18-bit output bus. A side output tells the producer which component kind the next slot wants, so the source can keep the four-slot chroma/luma cycle.

If the source has no component ready for an active slot, the block fills the slot with black level and leaves the data-ready strobe inactive. It also latches an underrun flag that stays set until reset. The nominal pixel clock is 27 MHz ±10%, so the logic must close timing at about 30 MHz.

Top module: `tv_field_sequencer`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `hsyncN`, `vsyncN` and `drdyN` are 1, `busOut`, `fieldOdd`, `underrun` and `inReady` are 0. After that the first vertical strobe edge starts an odd field.
- R2: `hsyncN` falls once every `cfgActive + cfgBlank` clocks (with `cfgBlank` ≥ 1) and stays low for exactly one clock.
- R3: Each line has exactly `cfgActive` slots, with `cfgActive` even. A slot is a clock with `inReady` = 1. A slot's output appears one clock later, and `drdyN` is low only on those output clocks, never while `hsyncN` is low.
- R4: The component drives `busOut[17:10]`, with component bit 7 on bus bit 17. `busOut[9:0]` is always 0. The whole bus is 0 outside slot outputs.
- R5: `wantComp` names the kind of each slot in a line in a repeating four-slot cycle: 0 = U, 1 = Y, 2 = V, 3 = Y. The cycle restarts at 0 on the first slot of every line.
- R6: At an odd-field start, `vsyncN` falls on the same clock as `hsyncN`, and `fieldOdd` becomes 1 on that clock.
- R7: At an even-field start, `vsyncN` falls E clocks after the `hsyncN` fall of the field's first line, and `fieldOdd` becomes 0. E is `cfgEvenOffset` when it is nonzero (it must be less than the line length). When `cfgEvenOffset` is 0, E is the line length divided by two, rounded down.
- R8: Each `vsyncN` low pulse lasts exactly `cfgVsWidth` clocks, with `cfgVsWidth` ≥ 1.
- R9: Fields alternate in parity, and each field lasts `cfgLines` lines. `fieldOdd` toggles on every `vsyncN` falling edge.
- R10: A slot with `inValid` = 0 outputs 0x10 on `busOut[17:10]` with `drdyN` = 1, and sets `underrun`. Once set, `underrun` stays 1 until reset.
- R11: Components taken on clocks with `inReady` and `inValid` both 1 appear on the bus one clock later, in the order they were taken, with `drdyN` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgActive | input | 12 | Active slots per line (even) |
| cfgBlank | input | 12 | Non-active clocks per line, including the sync pulse |
| cfgLines | input | 11 | Lines per field |
| cfgVsWidth | input | 12 | Vertical strobe low width in clocks |
| cfgEvenOffset | input | 12 | Even-field vertical edge offset; 0 selects half a line |
| inData | input | 8 | Component from the source |
| inValid | input | 1 | Source holds a component |
| inReady | output | 1 | Current clock is an active slot |
| wantComp | output | 2 | Component kind wanted by the current slot |
| hsyncN | output | 1 | Horizontal strobe, active low |
| vsyncN | output | 1 | Vertical strobe, active low |
| drdyN | output | 1 | Data-ready strobe, active low |
| busOut | output | 18 | Output data bus, component in bits 17:10 |
| fieldOdd | output | 1 | Parity of the field in progress |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The embedded properties assume that every configuration input is held constant outside reset. They also assume the settings are legal: a line of at least two clocks, a vertical pulse of at least one clock that is shorter than a field, and an even-field offset inside the line. The bench changes the configuration only while reset is asserted, and each scenario uses a legal set, including an odd line length, a one-clock vertical pulse and the half-line default. Source starvation is produced deliberately, in only one scenario, to exercise the fill and sticky-flag path.

// File: rtl/tvseq_pkg.sv
package tvseq_pkg;

  // Kind of component requested by an active slot
  typedef enum logic [1:0] {
    CK_U  = 2'd0,
    CK_Y0 = 2'd1,
    CK_V  = 2'd2,
    CK_Y1 = 2'd3
  } compKind_e;

  // Strobes passed from timing control to the datapath, one per clock
  typedef struct packed {
    logic      hsAct;    // horizontal sync clock
    logic      vsAct;    // vertical sync low interval
    logic      vsStart;  // first clock of a vertical pulse
    logic      slot;     // active component slot
    compKind_e phase;    // kind of the slot
  } seqStrobe_t;

  localparam logic [7:0] FILL_CODE = 8'h10;

endpackage

// File: rtl/tvseq_ctrl.sv
module tvseq_ctrl
  import tvseq_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgActive,
  input  logic [CNT_W-1:0]  cfgBlank,
  input  logic [LINE_W-1:0] cfgLines,
  input  logic [CNT_W-1:0]  cfgVsWidth,
  input  logic [CNT_W-1:0]  cfgEvenOffset,
  output seqStrobe_t        strobe
);

  localparam int LEN_W = CNT_W + 1;

  logic              primed;
  logic [LEN_W-1:0]  col;
  logic [LINE_W-1:0] line;
  logic              curOdd;
  logic [CNT_W-1:0]  vsLeft;

  logic [LEN_W-1:0]  lineLen;
  logic [LEN_W-1:0]  lastCol;
  logic [LEN_W-1:0]  evenPos;
  logic [LEN_W-1:0]  colM1;
  logic              atLineEnd;
  logic              atFieldEnd;
  logic              hsStart;
  logic              vsStart;
  logic              slot;

  always_comb begin
    lineLen    = {1'b0, cfgActive} + {1'b0, cfgBlank};
    lastCol    = lineLen - LEN_W'(1);
    evenPos    = (cfgEvenOffset == '0) ? (lineLen >> 1) : {1'b0, cfgEvenOffset};
    colM1      = col - LEN_W'(1);
    atLineEnd  = (col == lastCol);
    atFieldEnd = (line == cfgLines - LINE_W'(1));
    hsStart    = primed && (col == '0);
    vsStart    = primed && (line == '0) &&
                 (curOdd ? (col == '0) : (col == evenPos));
    slot       = primed && (col != '0) && (col <= {1'b0, cfgActive});
  end

  // Position counters: one clock of idle after reset, then odd field line 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed <= 1'b0;
      col    <= '0;
      line   <= '0;
      curOdd <= 1'b0;
    end else if (!primed) begin
      primed <= 1'b1;
      col    <= '0;
      line   <= '0;
      curOdd <= 1'b1;
    end else if (atLineEnd) begin
      col <= '0;
      if (atFieldEnd) begin
        line   <= '0;
        curOdd <= !curOdd;
      end else begin
        line <= line + LINE_W'(1);
      end
    end else begin
      col <= col + LEN_W'(1);
    end
  end

  // Vertical pulse width counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsLeft <= '0;
    end else if (vsStart) begin
      vsLeft <= cfgVsWidth - CNT_W'(1);
    end else if (vsLeft != '0) begin
      vsLeft <= vsLeft - CNT_W'(1);
    end
  end

  always_comb begin
    strobe.hsAct   = hsStart;
    strobe.vsAct   = vsStart || (vsLeft != '0);
    strobe.vsStart = vsStart;
    strobe.slot    = slot;
    strobe.phase   = compKind_e'(colM1[1:0]);
  end

  // R2
  col_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (col < lineLen));

  // R9
  line_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (line < cfgLines));

  // R9
  field_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && atLineEnd && atFieldEnd) |=> ((line == '0) && (curOdd != $past(curOdd))));

  // R8
  vs_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    vsLeft < cfgVsWidth);

endmodule

// File: rtl/tvseq_dpath.sv
module tvseq_dpath
  import tvseq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUS_W    = 18,
  parameter int LANE_LSB = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              drdyN,
  output logic [BUS_W-1:0]  busOut,
  output logic              fieldOdd,
  output logic              underrun
);

  localparam int LANE_MSB = LANE_LSB + DATA_W - 1;

  logic [DATA_W-1:0] laneReg;

  assign inReady = strobe.slot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsyncN   <= 1'b1;
      vsyncN   <= 1'b1;
      drdyN    <= 1'b1;
      laneReg  <= '0;
      fieldOdd <= 1'b0;
      underrun <= 1'b0;
    end else begin
      hsyncN   <= !strobe.hsAct;
      vsyncN   <= !strobe.vsAct;
      fieldOdd <= fieldOdd ^ strobe.vsStart;
      if (strobe.slot) begin
        if (inValid) begin
          laneReg <= inData;
          drdyN   <= 1'b0;
        end else begin
          laneReg  <= DATA_W'(FILL_CODE);
          drdyN    <= 1'b1;
          underrun <= 1'b1;
        end
      end else begin
        laneReg <= '0;
        drdyN   <= 1'b1;
      end
    end
  end

  // Place the component lane inside the wide bus
  for (genvar b = 0; b < BUS_W; b++) begin : g_bus
    if (b >= LANE_LSB && b <= LANE_MSB) begin : g_lane
      assign busOut[b] = laneReg[b - LANE_LSB];
    end else begin : g_zero
      assign busOut[b] = 1'b0;
    end
  end

  // R2
  hs_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hsyncN |=> hsyncN);

  // R3
  drdy_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drdyN |-> hsyncN);

  // R6
  odd_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(vsyncN) && fieldOdd) |-> $fell(hsyncN));

  // R7
  even_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(vsyncN) && !fieldOdd) |-> hsyncN);

  // R9
  parity_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsyncN) |-> (fieldOdd != $past(fieldOdd)));

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

endmodule

// File: rtl/tv_field_sequencer.sv
module tv_field_sequencer
  import tvseq_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LINE_W   = 11,
  parameter int DATA_W   = 8,
  parameter int BUS_W    = 18,
  parameter int LANE_LSB = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgActive,
  input  logic [CNT_W-1:0]  cfgBlank,
  input  logic [LINE_W-1:0] cfgLines,
  input  logic [CNT_W-1:0]  cfgVsWidth,
  input  logic [CNT_W-1:0]  cfgEvenOffset,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [1:0]        wantComp,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              drdyN,
  output logic [BUS_W-1:0]  busOut,
  output logic              fieldOdd,
  output logic              underrun
);

  seqStrobe_t strobe;

  tvseq_ctrl #(
    .CNT_W (CNT_W),
    .LINE_W(LINE_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgActive    (cfgActive),
    .cfgBlank     (cfgBlank),
    .cfgLines     (cfgLines),
    .cfgVsWidth   (cfgVsWidth),
    .cfgEvenOffset(cfgEvenOffset),
    .strobe       (strobe)
  );

  tvseq_dpath #(
    .DATA_W  (DATA_W),
    .BUS_W   (BUS_W),
    .LANE_LSB(LANE_LSB)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .inValid (inValid),
    .inReady (inReady),
    .hsyncN  (hsyncN),
    .vsyncN  (vsyncN),
    .drdyN   (drdyN),
    .busOut  (busOut),
    .fieldOdd(fieldOdd),
    .underrun(underrun)
  );

  assign wantComp = strobe.phase;

endmodule

// File: tb/tv_field_sequencer_tb.sv
module tv_field_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] cfgActive = 12'd8;
  logic [11:0] cfgBlank = 12'd4;
  logic [10:0] cfgLines = 11'd3;
  logic [11:0] cfgVsWidth = 12'd2;
  logic [11:0] cfgEvenOffset = 12'd0;
  logic [7:0]  inData = 8'h20;
  logic        inValid;
  logic        inReady;
  logic [1:0]  wantComp;
  logic        hsyncN, vsyncN, drdyN, fieldOdd, underrun;
  logic [17:0] busOut;
  logic        starve = 1'b0;

  assign inValid = !starve;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  tv_field_sequencer u_dut (
    .clk(clk), .rstN(rstN),
    .cfgActive(cfgActive), .cfgBlank(cfgBlank), .cfgLines(cfgLines),
    .cfgVsWidth(cfgVsWidth), .cfgEvenOffset(cfgEvenOffset),
    .inData(inData), .inValid(inValid), .inReady(inReady), .wantComp(wantComp),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .drdyN(drdyN), .busOut(busOut),
    .fieldOdd(fieldOdd), .underrun(underrun)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitor and source model (negedge) ----------------
  int  cyc = 0;
  int  lineLen, evenOff;
  bit  prevH, prevV, prevF;
  bit  hSeen, vSeen, lastVOdd;
  int  lastHFall, lastVFall, slotCount, vLow, vFallCount;
  bit  pSlot, pValid;
  logic [7:0] pData;

  always @(negedge clk) begin
    cyc++;
    lineLen = int'(cfgActive) + int'(cfgBlank);
    evenOff = (cfgEvenOffset == 0) ? lineLen / 2 : int'(cfgEvenOffset);
    if (!rstN) begin
      prevH = 1; prevV = 1; prevF = 0; hSeen = 0; vSeen = 0;
      slotCount = 0; vLow = 0; pSlot = 0; pValid = 0;
    end else begin
      // R11 / R4 / R10: output of the slot decided on the previous clock
      if (pSlot && pValid) begin
        check(drdyN == 0, "R11", "drdyN on taken slot", drdyN, 0);
        check(busOut == (18'(pData) << 10), "R11", "bus data", busOut, 18'(pData) << 10);
        inData = inData + 8'd7;
      end else if (pSlot) begin
        check(drdyN == 1, "R10", "drdyN on starved slot", drdyN, 1);
        check(busOut == (18'h10 << 10), "R10", "fill code", busOut, 18'h10 << 10);
        check(underrun == 1, "R10", "underrun set", underrun, 1);
      end else begin
        check(drdyN == 1, "R3", "drdyN outside slot", drdyN, 1);
        check(busOut == 0, "R4", "bus idle", busOut, 0);
      end
      // R2: one-clock horizontal pulse and line period
      if (!prevH) check(hsyncN == 1, "R2", "hsync low width", hsyncN, 1);
      if (prevH && !hsyncN) begin
        if (hSeen) begin
          check(cyc - lastHFall == lineLen, "R2", "line period", cyc - lastHFall, lineLen);
          check(slotCount == int'(cfgActive), "R3", "slots per line", slotCount, cfgActive);
        end
        hSeen = 1; lastHFall = cyc; slotCount = 0;
      end
      // vertical strobe
      if (prevV && !vsyncN) begin
        vFallCount++;
        check(fieldOdd != prevF, "R9", "parity toggle", fieldOdd, !prevF);
        if (fieldOdd) begin
          check(prevH && !hsyncN, "R6", "odd edge aligned", hsyncN, 0);
          if (vSeen) check(cyc - lastVFall == int'(cfgLines) * lineLen - evenOff,
                           "R9", "even-to-odd spacing", cyc - lastVFall,
                           int'(cfgLines) * lineLen - evenOff);
        end else begin
          check(hSeen && (cyc - lastHFall == evenOff), "R7", "even edge offset",
                cyc - lastHFall, evenOff);
          if (vSeen) check(cyc - lastVFall == int'(cfgLines) * lineLen + evenOff,
                           "R9", "odd-to-even spacing", cyc - lastVFall,
                           int'(cfgLines) * lineLen + evenOff);
        end
        if (!vSeen) check(fieldOdd == 1, "R1", "first field odd", fieldOdd, 1);
        vSeen = 1; lastVFall = cyc; lastVOdd = fieldOdd;
      end
      if (!vsyncN) vLow++;
      if (!prevV && vsyncN) begin
        check(vLow == int'(cfgVsWidth), "R8", "vsync width", vLow, cfgVsWidth);
        vLow = 0;
      end
      // R5: slot kind cycle U,Y,V,Y = 0,1,2,3
      if (inReady) begin
        check(wantComp == 2'(slotCount), "R5", "component kind", wantComp, slotCount % 4);
        slotCount++;
      end
      pSlot = inReady; pValid = inValid; pData = inData;
      prevH = hsyncN; prevV = vsyncN; prevF = fieldOdd;
    end
  end

  // ---------------- scenarios ----------------
  task automatic check_idle(input string tag);
    check(hsyncN == 1 && vsyncN == 1 && drdyN == 1, "R1", {tag, " strobes"},
          {hsyncN, vsyncN, drdyN}, 3'b111);
    check(busOut == 0 && fieldOdd == 0 && underrun == 0 && inReady == 0, "R1",
          {tag, " outputs"}, {busOut, fieldOdd, underrun, inReady}, 0);
  endtask

  task automatic apply_reset(input int act, input int blank, input int lines,
                             input int vsw, input int eoff);
    @(posedge clk); #2;
    rstN = 1'b0; starve = 1'b0;
    cfgActive = 12'(act); cfgBlank = 12'(blank); cfgLines = 11'(lines);
    cfgVsWidth = 12'(vsw); cfgEvenOffset = 12'(eoff);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check_idle("in reset");
    @(posedge clk); #2;
    rstN = 1'b1;
    @(negedge clk); #1;
    check_idle("first clock after reset");
  endtask

  task automatic run_steady(input int fields);
    int startFalls;
    int len;
    startFalls = vFallCount;
    len = int'(cfgActive) + int'(cfgBlank);
    repeat (fields * int'(cfgLines) * len + 8) @(posedge clk);
    #2;
    check(vFallCount - startFalls >= fields, "R9", "field count",
          vFallCount - startFalls, fields);
    check(underrun == 0, "R10", "no underrun when fed", underrun, 0);
  endtask

  task automatic run_underrun();
    do begin @(posedge clk); #2; end while (!inReady);
    starve = 1'b1;
    repeat (3) @(posedge clk);
    #2; starve = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check(underrun == 1, "R10", "underrun raised", underrun, 1);
    repeat (60) @(posedge clk);
    #2;
    check(underrun == 1, "R10", "underrun sticky", underrun, 1);
  endtask

  initial begin
    vFallCount = 0;
    apply_reset(8, 4, 3, 2, 0);     // half-line default, even line
    run_steady(3);
    run_underrun();
    repeat (40) @(posedge clk);
    apply_reset(6, 6, 4, 5, 3);     // explicit offset, wide pulse; clears flag
    run_steady(3);
    apply_reset(4, 3, 2, 1, 5);     // odd line length, one-clock pulse
    run_steady(4);
    apply_reset(6, 5, 2, 3, 0);     // odd line length with half-line default
    run_steady(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule